// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a single bank of general-purpose pins. Each pin can be driven from an output latch when its direction bit selects output, and every pin's level is sampled back through a two-stage synchronizer. The synchronized value can be read from an input register. A host reaches all of the bank's state through a small register port: an address, a write strobe, write data and registered read data.

Each pin can also raise an interrupt. Three configuration bits per pin select the condition. The first selects edge or level sensing. The second selects the rising or falling edge. The third selects the high or low level. A mask bit per pin, active when set, blocks detection. Detected events collect in a sticky status register. Writing to that register keeps only the bits written as one, so writing zero clears everything. A single registered summary line reports that some status bit is pending, for use by an interrupt aggregator higher up. Detection on both edges is done by software, which flips the edge-polarity bit after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset, the output latch, the direction register, the trigger, edge and level registers and the status register read zero. The mask register reads all ones, `pin_oe` and `pin_out` are zero and `irq_out` is low.
- R2: Writes to address 0 (output latch) and address 1 (direction) are readable at the same addresses. `pin_out` follows the output latch and `pin_oe` follows the direction register, where 1 means output.
- R3: Address 2 returns the pin inputs after a two-flop synchronizer. Writes to address 2 have no effect.
- R4: With the trigger bit at address 4 set to 1 (edge mode), an edge bit at address 5 of 1 sets the pin's status on a rising edge and 0 sets it on a falling edge. The opposite edge sets nothing.
- R5: With the trigger bit at 0 (level mode), a level bit at address 6 of 1 flags a high pin and 0 flags a low pin. While the level persists, the status bit is set again on every cycle, so a clear does not stick.
- R6: A mask bit of 1 at address 3 stops its pin from setting status, whatever the trigger condition. A mask bit of 0 enables the pin.
- R7: The status register at address 7 is sticky. A write to it keeps only the bits written as one, so writing zero clears every bit that has no new event. An event in the same cycle as the write still sets its bit.
- R8: `irq_out` is high exactly one cycle after the status register is nonzero, and it falls once the status register is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | NUM_PINS | Write data |
| reg_rdata | output | NUM_PINS | Read data, registered, for the address of the previous cycle |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch value to the pads |
| pin_oe | output | NUM_PINS | Pad output enable, 1 = drive |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
The bench uses the default parameters: sixteen pins and a two-stage synchronizer. With these defaults the lowest pin, the highest pin and pins in the middle of the bank all appear in the trigger table. The timing the checks wait for is the real latency of three edges from a pin change to a status bit. Under this configuration the table covers both edge polarities and both level polarities, each with a case that fires and a case that must not. Directed tests then cover masking, a selective clear, a clear against a level that is still held, and the summary line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_OUT   = 3'd0,
    A_DIR   = 3'd1,
    A_IN    = 3'd2,
    A_MASK  = 3'd3,
    A_TRIG  = 3'd4,
    A_EDGE  = 3'd5,
    A_LVL   = 3'd6,
    A_STAT  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] samp,
  input  logic [W-1:0] trig_edge,
  input  logic [W-1:0] edge_rise,
  input  logic [W-1:0] lvl_high,
  input  logic [W-1:0] mask,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= samp;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall, cond;
    always_comb begin
      rise = samp[g] & ~prev_q[g];
      fall = ~samp[g] & prev_q[g];
      if (trig_edge[g]) cond = edge_rise[g] ? rise : fall;
      else              cond = lvl_high[g] ? samp[g] : ~samp[g];
      hit[g] = cond & ~mask[g];
    end
  end

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    ((hit & trig_edge & ~(samp ^ prev_q)) == '0)); // R4
  AST_LEVEL_MATCHES_PIN: assert property (@(posedge clk) disable iff (rst)
    ((hit & ~trig_edge & (samp ^ lvl_high)) == '0)); // R5
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  localparam logic [NUM_PINS-1:0] ALL_ONES = '1;

  logic [NUM_PINS-1:0] out_q, dir_q, mask_q, trig_q, edge_q, lvl_q, stat_q;
  logic [NUM_PINS-1:0] samp, hit, keep;
  logic                irq_q;
  reg_sel_e            sel;

  assign sel = reg_sel_e'(reg_addr);

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(samp)
  );

  gpio_trig_detect #(.W(NUM_PINS)) u_det (
    .clk(clk), .rst(rst), .samp(samp), .trig_edge(trig_q),
    .edge_rise(edge_q), .lvl_high(lvl_q), .mask(mask_q), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= ALL_ONES;
      trig_q <= '0;
      edge_q <= '0;
      lvl_q  <= '0;
    end else if (reg_wr) begin
      case (sel)
        A_OUT:  out_q  <= reg_wdata;
        A_DIR:  dir_q  <= reg_wdata;
        A_MASK: mask_q <= reg_wdata;
        A_TRIG: trig_q <= reg_wdata;
        A_EDGE: edge_q <= reg_wdata;
        A_LVL:  lvl_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign keep = (reg_wr && sel == A_STAT) ? reg_wdata : ALL_ONES;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & keep) | hit;
      irq_q  <= |stat_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (sel)
        A_OUT:  reg_rdata <= out_q;
        A_DIR:  reg_rdata <= dir_q;
        A_IN:   reg_rdata <= samp;
        A_MASK: reg_rdata <= mask_q;
        A_TRIG: reg_rdata <= trig_q;
        A_EDGE: reg_rdata <= edge_q;
        A_LVL:  reg_rdata <= lvl_q;
        A_STAT: reg_rdata <= stat_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_out = irq_q;

  AST_OE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_oe) |-> $past(reg_wr && reg_addr == A_DIR)); // R2
  AST_SET_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (rst)
    ((~$past(stat_q) & stat_q & $past(mask_q)) == '0)); // R6
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (($past(stat_q) & ~stat_q) != '0) |-> $past(reg_wr && reg_addr == A_STAT)); // R7
  AST_IRQ_FOLLOWS_STAT: assert property (@(posedge clk) disable iff (rst)
    (stat_q != '0) |=> irq_out); // R8
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    (stat_q == '0) |=> !irq_out); // R8
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic         irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // vector: pin[9:6], trig_edge[5], edge_rise[4], lvl_high[3], v0[2], v1[1], exp[0]
  localparam logic [9:0] VEC [8] = '{
    {4'd3,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd5,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd15, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    rd(3'd0, r); chk("R1 out", r, '0);
    rd(3'd1, r); chk("R1 dir", r, '0);
    rd(3'd3, r); chk("R1 mask", r, 16'hFFFF);
    rd(3'd4, r); chk("R1 trig", r, '0);
    rd(3'd7, r); chk("R1 stat", r, '0);
    chk("R1 pins", {pin_out | pin_oe}, '0);
    chk("R1 irq", {15'd0, irq_out}, '0);

    // R2 output latch and direction
    wr(3'd0, 16'hA5A5); wr(3'd1, 16'h00FF);
    rd(3'd0, r); chk("R2 out readback", r, 16'hA5A5);
    rd(3'd1, r); chk("R2 dir readback", r, 16'h00FF);
    chk("R2 pin_out", pin_out, 16'hA5A5);
    chk("R2 pin_oe", pin_oe, 16'h00FF);

    // R3 input status, and writes to it ignored
    pin_in = 16'h3C81;
    cyc(3);
    rd(3'd2, r); chk("R3 input", r, 16'h3C81);
    wr(3'd2, 16'h0000);
    rd(3'd2, r); chk("R3 input write ignored", r, 16'h3C81);
    pin_in = '0;
    cyc(4);

    // R4 / R5 table walk
    for (int v = 0; v < 8; v++) begin
      logic [3:0] p;
      logic [N-1:0] bit1;
      p = VEC[v][9:6];
      bit1 = N'(1) << p;
      wr(3'd3, 16'hFFFF);
      pin_in[p] = VEC[v][2];
      cyc(6);
      wr(3'd4, VEC[v][5] ? bit1 : '0);
      wr(3'd5, VEC[v][4] ? bit1 : '0);
      wr(3'd6, VEC[v][3] ? bit1 : '0);
      wr(3'd7, '0);
      wr(3'd3, ~bit1);
      cyc(2);
      pin_in[p] = VEC[v][1];
      cyc(6);
      rd(3'd7, r);
      chk(VEC[v][5] ? "R4 edge vector" : "R5 level vector", r, VEC[v][0] ? bit1 : '0);
      wr(3'd3, 16'hFFFF);
      wr(3'd7, '0);
      pin_in = '0;
      cyc(6);
    end

    // R6 masked pin with a rising edge sets nothing
    wr(3'd4, 16'h0010); wr(3'd5, 16'h0010); wr(3'd3, 16'hFFFF); wr(3'd7, '0);
    pin_in[4] = 1'b1;
    cyc(6);
    rd(3'd7, r); chk("R6 masked status", r, '0);
    chk("R6 masked irq", {15'd0, irq_out}, '0);
    pin_in = '0;
    cyc(6);

    // R7 selective clear, R8 summary line
    wr(3'd4, 16'h0028); wr(3'd5, 16'h0028); wr(3'd7, '0); wr(3'd3, 16'hFFD7);
    cyc(2);
    pin_in = 16'h0028;
    cyc(6);
    rd(3'd7, r); chk("R7 both set", r, 16'h0028);
    chk("R8 irq high", {15'd0, irq_out}, 16'h0001);
    wr(3'd7, 16'h0008);
    rd(3'd7, r); chk("R7 keep written ones", r, 16'h0008);
    wr(3'd7, 16'h0000);
    rd(3'd7, r); chk("R7 zero clears", r, '0);
    chk("R8 irq low", {15'd0, irq_out}, '0);
    wr(3'd3, 16'hFFFF);
    pin_in = '0;
    cyc(6);

    // R5 persistent level re-sets after clear
    wr(3'd4, '0); wr(3'd6, '0); wr(3'd7, '0);
    wr(3'd3, 16'hFDFF);
    cyc(4);
    wr(3'd7, '0);
    cyc(1);
    rd(3'd7, r); chk("R5 level persists", r, 16'h0200);
    wr(3'd3, 16'hFFFF);
    wr(3'd7, '0);
    rd(3'd7, r); chk("R7 clear after mask", r, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule